// File: doc/BRIEF.md
# I2C Target with Byte Register File

This block lets an I2C bus master reach a 256-byte register file held inside the block. It watches the open-drain clock and data lines and sends them through two-flop synchronisers into a fast system clock domain. Its only bus output is a pull-down enable for the data line. The block finds START and STOP conditions and answers one fixed 7-bit device address. A sub-address byte sets an internal pointer. After that, the master can write a run of bytes to consecutive registers, or read bytes starting at the current pointer.

A repeated START keeps the pointer. This gives the usual access pattern: write the sub-address, issue a repeated START, then read. A read that starts straight after the address byte returns data from wherever the pointer was left. On its own side, the host logic reads any register combinationally and writes any register with a single-cycle strobe.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the pointer is 0x00, the data pull-down is off, and every register reads 0x00 on the host port.
- R2: A rising data edge while the clock is high (STOP) returns the block to idle and releases the data line. Bytes clocked after a STOP with no new START get no ACK and change nothing.
- R3: A falling data edge while the clock is high (START) begins address matching. The first byte is taken MSB first: bits 7..1 are the device address 0x1A, and bit 0 selects read (1) or write (0). On a match the block pulls the data line low for the 9th clock. On a mismatch it leaves the line released and ignores the bus until the next START, so the registers and the pointer stay unchanged.
- R4: In a write transfer, the byte after the address byte is loaded into the pointer and is acknowledged.
- R5: Each further write byte is stored at the pointer and acknowledged, and the pointer then increments. The pointer wraps from 0xFF to 0x00.
- R6: A read that follows the address byte directly returns the register at the current pointer, MSB first. The block changes the data line only while the clock is low.
- R7: After each read byte the block samples the master's acknowledge bit. On ACK (low) it increments the pointer, wrapping from 0xFF to 0x00, and sends the next register. On NACK (high) it releases the line, does not increment, and waits for STOP or START.
- R8: A repeated START keeps the pointer. A sub-address write followed by a repeated START and a read therefore returns data from that sub-address. The pointer changes only at a falling clock edge.
- R9: The host port returns the register at the host address combinationally. A host write strobe stores the host data on the next clock, and later bus reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_pd_o | output | 1 | High pulls the data line low |
| hst_addr_i | input | AW | Host register address |
| hst_we_i | input | 1 | Host write strobe |
| hst_wdata_i | input | 8 | Host write data |
| hst_rdata_o | output | 8 | Register at the host address |

## Verification
Two cases are hard to reach from the pins: the pointer wrapping inside a single transfer, and the pointer staying put across a repeated START or after a NACK. The bench preloads all 256 registers through the host port with an arithmetic pattern. It then runs a five-byte write from sub-address 0xFD and a two-byte read from 0xFF, so the wrap happens in the middle of a burst. After that, back-to-back current-address reads show whether the pointer moved. A sweep over all 128 device addresses, plus bytes clocked with no START, checks that foreign traffic leaves both the pointer and the registers untouched.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pd_o,
  input  logic [AW-1:0] hst_addr_i,
  input  logic          hst_we_i,
  input  logic [7:0]    hst_wdata_i,
  output logic [7:0]    hst_rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = 1;
  localparam logic [3:0] S_IDLE = 4'd0, S_DEV = 4'd1, S_DEV_ACK = 4'd2,
                         S_SUB = 4'd3, S_SUB_ACK = 4'd4, S_WR = 4'd5,
                         S_WR_ACK = 4'd6, S_RD = 4'd7, S_RD_ACK = 4'd8;

  logic [2:0] scl_sy, sda_sy;
  logic scl_s, scl_q, sda_s, sda_q;
  logic start, stop, scl_rise, scl_fall;

  logic [3:0]    state;
  logic [2:0]    bitcnt;
  logic          full, rw, mack;
  logic [7:0]    rx, tx;
  logic [AW-1:0] ptr, ptr_nx;
  logic [7:0]    mem [DEPTH];
  logic          bus_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  assign scl_s = scl_sy[1];
  assign scl_q = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_q = sda_sy[2];

  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  assign ptr_nx = ptr + ONE;
  assign bus_we = (state == S_WR) && scl_fall && full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      full   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
    end else if (start) begin
      state  <= S_DEV;
      bitcnt <= '0;
      full   <= 1'b0;
    end else if (stop) begin
      state  <= S_IDLE;
    end else begin
      case (state)
        S_DEV, S_SUB, S_WR:
          if (scl_rise && !full) begin
            rx     <= {rx[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            full   <= (bitcnt == 3'd7);
          end else if (scl_fall && full) begin
            full <= 1'b0;
            if (state == S_DEV) begin
              if (rx[7:1] == DEV_ADDR) begin
                rw    <= rx[0];
                state <= S_DEV_ACK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_SUB) begin
              ptr   <= rx[AW-1:0];
              state <= S_SUB_ACK;
            end else begin
              ptr   <= ptr_nx;
              state <= S_WR_ACK;
            end
          end
        S_DEV_ACK:
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              tx    <= mem[ptr];
              state <= S_RD;
            end else begin
              state <= S_SUB;
            end
          end
        S_SUB_ACK, S_WR_ACK:
          if (scl_fall) state <= S_WR;
        S_RD:
          if (scl_fall) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) state <= S_RD_ACK;
            else tx <= {tx[6:0], 1'b0};
          end
        S_RD_ACK:
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              ptr    <= ptr_nx;
              tx     <= mem[ptr_nx];
              bitcnt <= '0;
              state  <= S_RD;
            end else begin
              state <= S_IDLE;
            end
          end
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (hst_we_i) mem[hst_addr_i] <= hst_wdata_i;
      if (bus_we) mem[ptr] <= rx;
    end

  assign hst_rdata_o = mem[hst_addr_i];

  assign sda_pd_o = (state == S_DEV_ACK) || (state == S_SUB_ACK) ||
                    (state == S_WR_ACK)  || ((state == S_RD) && !tx[7]);
endmodule

module i2c_reg_target_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pd_o,
  input logic          scl_s,
  input logic          stop,
  input logic          scl_fall,
  input logic          full,
  input logic [3:0]    state,
  input logic [7:0]    rx,
  input logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = 1;

  p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> !scl_s);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_pd_o);

  p_ack_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd2) |-> (rx[7:1] == DEV_ADDR));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd5 && scl_fall && full) |=> (ptr == $past(ptr) + ONE));

  p_ptr_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pd_o(sda_pd_o), .scl_s(scl_s), .stop(stop),
  .scl_fall(scl_fall), .full(full), .state(state), .rx(rx), .ptr(ptr)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pd, sda_line;
  logic [7:0] hst_addr = '0, hst_wdata = '0, hst_rdata;
  logic hst_we = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [256];

  assign sda_line = m_sda & ~sda_pd;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pd_o(sda_pd),
    .hst_addr_i(hst_addr), .hst_we_i(hst_we), .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    acked = !sda_line;
    wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq();
      b[i] = sda_line;
      wq(); m_scl = 1'b0; wq();
    end
    m_sda = !give_ack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_we = 1'b1;
    @(negedge clk); hst_we = 1'b0;
    exp_mem[a] = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(sda_pd == 1'b0, "R1 pull-down off", sda_pd, 0);
    for (int i = 0; i < 256; i++) begin
      hst_addr = 8'(i); #1;
      check(hst_rdata == 8'h00, "R1 register cleared", hst_rdata, 0);
    end

    // R9 preload and readback through host port
    for (int i = 0; i < 256; i++) host_write(8'(i), 8'((i * 37 + 5) & 255));
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); hst_addr = 8'(i); #1;
      check(hst_rdata == exp_mem[i], "R9 host readback", hst_rdata, exp_mem[i]);
    end

    // R3 device address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      check(ack == (a == 7'h1A), "R3 address ack", ack, (a == 7'h1A));
      bus_stop();
    end

    // R3 mismatch: following bytes ignored
    bus_start();
    send_byte(8'h40, ack); check(!ack, "R3 foreign address nack", ack, 0);
    send_byte(8'h05, ack); check(!ack, "R3 foreign byte ignored", ack, 0);
    send_byte(8'hAA, ack); check(!ack, "R3 foreign byte ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h37, ack); check(!ack, "R3 foreign read address nack", ack, 0);
    bus_stop();
    hst_addr = 8'h05; #1;
    check(hst_rdata == exp_mem[5], "R3 register untouched", hst_rdata, exp_mem[5]);
    bus_start();
    send_byte(8'h35, ack); check(ack, "R6 read address ack", ack, 1);
    recv_byte(1'b0, d); check(d == exp_mem[0], "R3 pointer untouched", d, exp_mem[0]);
    bus_stop();

    // R4/R5 multi-byte write with wrap
    bus_start();
    send_byte(8'h34, ack); check(ack, "R3 write address ack", ack, 1);
    send_byte(8'hFD, ack); check(ack, "R4 sub-address ack", ack, 1);
    for (int k = 0; k < 5; k++) begin
      send_byte(8'hC0 + 8'(k), ack);
      check(ack, "R5 data ack", ack, 1);
      exp_mem[8'(8'hFD + k)] = 8'hC0 + 8'(k);
    end
    bus_stop();
    check(sda_pd == 1'b0, "R2 released after stop", sda_pd, 0);
    for (int k = 0; k < 5; k++) begin
      hst_addr = 8'(8'hFD + k); #1;
      check(hst_rdata == exp_mem[hst_addr], "R5 stored with wrap", hst_rdata, exp_mem[hst_addr]);
      @(negedge clk);
    end

    // R6 current-address read, pointer now 0x02
    bus_start();
    send_byte(8'h35, ack);
    recv_byte(1'b0, d); check(d == exp_mem[2], "R6 current read", d, exp_mem[2]);
    bus_stop();

    // R2 bytes without START ignored
    send_byte(8'hD5, ack); check(!ack, "R2 no ack without start", ack, 0);
    hst_addr = 8'h02; #1;
    check(hst_rdata == exp_mem[2], "R2 register untouched", hst_rdata, exp_mem[2]);

    // R7 NACK leaves pointer
    bus_start();
    send_byte(8'h35, ack);
    recv_byte(1'b0, d); check(d == exp_mem[2], "R7 no increment on nack", d, exp_mem[2]);
    bus_stop();

    // R8 sub-address then repeated START read, R7 burst
    bus_start();
    send_byte(8'h34, ack);
    send_byte(8'h10, ack); check(ack, "R4 sub-address ack", ack, 1);
    bus_start();
    send_byte(8'h35, ack); check(ack, "R8 read after repeated start", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, d);
      check(d == exp_mem[8'h10 + k], "R8 burst read", d, exp_mem[8'h10 + k]);
    end
    bus_stop();
    bus_start();
    send_byte(8'h35, ack);
    recv_byte(1'b0, d); check(d == exp_mem[8'h13], "R7 pointer after burst", d, exp_mem[8'h13]);
    bus_stop();

    // R9 host overwrite seen by bus, R7 read wrap
    host_write(8'hFF, 8'h5A);
    bus_start();
    send_byte(8'h34, ack);
    send_byte(8'hFF, ack);
    bus_start();
    send_byte(8'h35, ack);
    recv_byte(1'b1, d); check(d == 8'h5A, "R9 host write seen by bus", d, 8'h5A);
    recv_byte(1'b0, d); check(d == exp_mem[0], "R7 read wrap", d, exp_mem[0]);
    bus_stop();
    check(sda_pd == 1'b0, "R2 released at end", sda_pd, 0);

    finish_run();
  end
endmodule